// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block steps a successive-approximation conversion. A start pulse, accepted only while the block is idle, begins a cycle. The block then drives a trial code to an external DAC, one bit at a time from the most significant bit down. It reads back a single comparator bit and keeps or drops each trial bit on that answer. At the end it loads the final code into a result register. The cycle length is fixed at the moment of start: the full width, or a short cycle that resolves only the upper bits.

A cycle cannot be cut short or restarted once it has begun. A busy flag frames the whole conversion. A one-cycle end-of-conversion pulse marks the cycle in which the result becomes valid. While a conversion runs, the result port reads zero, so no partial code can be read out. The analog parts and the bus-side formatting live outside this block.

Top module: `sar_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `busy_o` and `eoc_o` are low and `result_o` and `trial_o` are all zeroes.
- R2: A high `start_i` while the block is idle is accepted at that clock edge. In the next cycle `busy_o` is high and `trial_o` has only its top bit (bit 11) set.
- R3: Each clock edge during a cycle resolves one bit, from bit 11 downwards. The bit is kept when `cmp_i` is low (trial code not above the input) and cleared when `cmp_i` is high, and the next lower bit is set for its trial. In a full cycle the final code is the largest 12-bit code that does not exceed the input.
- R4: `short_i` is sampled with the accepted start. When it is low, `busy_o` stays high for exactly 12 cycles. When it is high, `busy_o` stays high for exactly 8 cycles.
- R5: In a short cycle, result bits 11..4 hold the largest such prefix not above the input, and bits 3..0 are zero.
- R6: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the cycle length nor the code produced.
- R7: `eoc_o` is a single-cycle pulse. It is high in the first cycle in which `busy_o` is low again after a conversion.
- R8: `result_o` reads all zeroes while `busy_o` is high. It shows the final code from the `eoc_o` cycle on and holds it until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start-of-conversion request |
| short_i | input | 1 | Short-cycle select, sampled with the accepted start |
| cmp_i | input | 1 | Comparator: high when the trial code is above the input |
| trial_o | output | 12 | Trial code driven to the DAC |
| busy_o | output | 1 | High for the whole conversion |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | 12 | Final code; zero while busy |

## Verification
Several rules are checked by assertions on every cycle. These are: the top-bit trial after an accepted start, the zero result while busy, the single-cycle end pulse at the busy fall, and a busy length that matches the mode captured at start. Zero low bits after a short cycle are also checked this way. Only the bench scenarios can show that the final code matches the input, since that needs a model of the comparator. The same holds for a start during busy leaving the code unchanged, and for the result holding after the end of a conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // index of the last bit resolved in a cycle
  function automatic int unsigned stop_index(input int unsigned width,
                                             input int unsigned short_width,
                                             input logic short_sel);
    return short_sel ? (width - short_width) : 0;
  endfunction
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int W  = 12,
  parameter int SW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         short_i,
  output logic         busy_o,
  output logic         eoc_o,
  output logic         load_o,
  output logic         done_o,
  output logic [W-1:0] ptr_oh_o
);
  import sar_pkg::*;
  localparam int IW = $clog2(W);

  logic          busy_q, eoc_q;
  logic [IW-1:0] idx_q, stop_q;

  assign load_o = !busy_q && start_i;
  assign done_o = busy_q && (idx_q == stop_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      eoc_q  <= 1'b0;
      idx_q  <= '0;
      stop_q <= '0;
    end else begin
      eoc_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        idx_q  <= IW'(W - 1);
        stop_q <= IW'(stop_index(W, SW, short_i));
      end else if (busy_q) begin
        if (idx_q == stop_q) begin
          busy_q <= 1'b0;
          eoc_q  <= 1'b1;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_ptr
    assign ptr_oh_o[i] = busy_q && (idx_q == IW'(i));
  end

  assign busy_o = busy_q;
  assign eoc_o  = eoc_q;
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         done_i,
  input  logic         cmp_i,
  input  logic [W-1:0] ptr_oh_i,
  output logic [W-1:0] code_q_o,
  output logic [W-1:0] code_d_o
);
  logic [W-1:0] code_q, code_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic next_trial;
    if (i < W - 1) begin : g_lower
      assign next_trial = ptr_oh_i[i+1] && !done_i;
    end else begin : g_top
      assign next_trial = 1'b0;
    end

    always_comb begin
      if (load_i)           code_d[i] = (i == W - 1);
      else if (ptr_oh_i[i]) code_d[i] = !cmp_i;
      else if (next_trial)  code_d[i] = 1'b1;
      else                  code_d[i] = code_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_d;
  end

  assign code_q_o = code_q;
  assign code_d_o = code_d;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W  = 12,
  parameter int SW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         short_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic         busy_o,
  output logic         eoc_o,
  output logic [W-1:0] result_o
);
  logic         load, done;
  logic [W-1:0] ptr_oh, code_q, code_d, result_q;

  sar_seq_ctrl #(.W(W), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i),
    .busy_o(busy_o), .eoc_o(eoc_o), .load_o(load), .done_o(done),
    .ptr_oh_o(ptr_oh)
  );

  sar_code_reg #(.W(W)) u_code (
    .clk(clk), .rst(rst), .load_i(load), .done_i(done), .cmp_i(cmp_i),
    .ptr_oh_i(ptr_oh), .code_q_o(code_q), .code_d_o(code_d)
  );

  always_ff @(posedge clk) begin
    if (rst || load) result_q <= '0;
    else if (done)   result_q <= code_d;
  end

  assign trial_o  = code_q;
  assign result_o = result_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int W  = 12,
  parameter int SW = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         short_i,
  input logic [W-1:0] trial_o,
  input logic         busy_o,
  input logic         eoc_o,
  input logic [W-1:0] result_o
);
  logic        mode_q;
  logic [15:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o && start_i) begin
      mode_q <= short_i;
      cnt_q  <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_START_TOP_TRIAL: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && trial_o == {1'b1, {(W-1){1'b0}}})); // R2
  AST_RESULT_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (result_o == '0)); // R8
  AST_EOC_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    eoc_o |-> (!busy_o && $past(busy_o))); // R7
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eoc_o |=> !eoc_o); // R7
  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    eoc_o |-> (cnt_q == (mode_q ? 16'(SW) : 16'(W)))); // R4
  AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (eoc_o && mode_q) |-> (result_o[W-SW-1:0] == '0)); // R5
endmodule

bind sar_seq sar_seq_chk #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i),
  .trial_o(trial_o), .busy_o(busy_o), .eoc_o(eoc_o), .result_o(result_o)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
  localparam int W = 12;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst, start_i, short_i, cmp_i;
  logic [W-1:0] trial_o, result_o;
  logic busy_o, eoc_o;
  int vin;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;
  assign cmp_i = (int'(trial_o) > vin);

  sar_seq uut (.clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i),
               .cmp_i(cmp_i), .trial_o(trial_o), .busy_o(busy_o),
               .eoc_o(eoc_o), .result_o(result_o));

  typedef struct packed { logic [15:0] vin; logic short_sel; logic [11:0] exp; } vec_t;
  localparam vec_t VEC [NV] = '{
    '{16'd0,    1'b0, 12'd0},    '{16'd4095, 1'b0, 12'd4095},
    '{16'd5000, 1'b0, 12'd4095}, '{16'd2048, 1'b0, 12'd2048},
    '{16'd2047, 1'b0, 12'd2047}, '{16'd1234, 1'b0, 12'd1234},
    '{16'd2748, 1'b0, 12'd2748}, '{16'd1234, 1'b1, 12'd1232},
    '{16'd4095, 1'b1, 12'd4080}, '{16'd15,   1'b1, 12'd0},
    '{16'd16,   1'b1, 12'd16},   '{16'd2748, 1'b1, 12'd2736}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one conversion; optional extra start pulse mid-cycle (R6)
  task automatic convert(input int v, input logic s, input int exp, input bit poke);
    int cyc;
    int cap;
    bit zero_ok;
    vin = v;
    @(negedge clk); start_i = 1'b1; short_i = s;
    @(negedge clk); start_i = 1'b0;
    check(busy_o && trial_o == 12'h800, "R2", int'(trial_o), 12'h800);
    cyc = 0; zero_ok = 1'b1;
    while (busy_o && cyc < 40) begin
      if (result_o != 0) zero_ok = 1'b0;
      if (poke && cyc == 3) begin start_i = 1'b1; short_i = !s; end
      else start_i = 1'b0;
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(cyc == (s ? 8 : 12), poke ? "R6" : "R4", cyc, s ? 8 : 12);
    check(zero_ok, "R8", zero_ok, 1);
    check(eoc_o == 1'b1, "R7", eoc_o, 1);
    check(result_o == exp[11:0], s ? "R5" : (poke ? "R6" : "R3"), int'(result_o), exp);
    cap = int'(result_o);
    @(negedge clk);
    check(!eoc_o && int'(result_o) == cap, "R7", int'(result_o), cap);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; short_i = 1'b0; vin = 0;
    repeat (3) @(negedge clk);
    check(!busy_o && !eoc_o && result_o == 0 && trial_o == 0, "R1", int'(result_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !eoc_o && result_o == 0 && trial_o == 0, "R1", int'(trial_o), 0);

    for (int k = 0; k < NV; k++)
      convert(int'(VEC[k].vin), VEC[k].short_sel, int'(VEC[k].exp), 1'b0);

    // start during a full cycle, with short select flipped: ignored
    convert(3000, 1'b0, 3000, 1'b1);
    // start during a short cycle: ignored
    convert(1000, 1'b1, 992, 1'b1);

    // reset mid-conversion
    vin = 500;
    @(negedge clk); start_i = 1'b1; short_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy_o && !eoc_o && result_o == 0 && trial_o == 0, "R1", int'(busy_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule